// File: doc/BRIEF.md
# DMA Controller Mask, Request and Status Unit

This block holds the controller-wide state of a four-channel DMA controller: the command byte, one mode byte per channel, the channel mask, and a status byte that combines pending requests with terminal-count flags. Software reaches it through a byte-wide register port addressed by a 4-bit index. Indices 8 to 15 are decoded for writes, and indices 8 and 15 return data on reads. Hardware request lines, one hold strobe and one release strobe per channel, update the same request bits that software writes. A transfer engine reports the end of a channel's block through a terminal-count strobe.

From this state the block computes which channels may be served: a channel qualifies when it is requested and not masked. It also names one channel to serve next, the lowest-numbered one that qualifies, unless the command byte has disabled the controller. The register read port is combinational. Every state change takes effect at the rising clock edge that samples the strobe. A byte-pointer clear pulse is passed to the address/count registers, which sit outside this block.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to index 8 loads the command byte only when the data is 0x00 or 0x04. Any other value leaves the command byte unchanged. Command bit 2 is the controller-disable bit.
- R2: A write to index 11 stores all eight data bits as the mode of the channel chosen by data[1:0]. Bit 5 of a mode selects address decrement, bit 4 auto-initialise, bits [3:2] the transfer type and bits [7:6] the operating mode. The modes of the other channels are unchanged.
- R3: A write to index 10 sets the mask bit of channel data[1:0] to data[2] and leaves the other mask bits alone.
- R4: A write to index 14 clears every mask bit. A write to index 15 loads mask bit c from data[c].
- R5: A write to index 9 sets status bit 4+c to data[2], where c = data[1:0], and clears status bit c.
- R6: A DREQ hold strobe sets status bit 4+c, and a release strobe clears it. A release beats a hold in the same cycle. A request write to that channel in the same cycle beats both.
- R7: Hardware reset and a write to index 13 set all mask bits to 1 and clear status and command. A write to index 12 or 13 raises ptr_clr in that cycle.
- R8: A read at index 8 returns the status byte, and the following edge clears status bits [3:0]. A terminal-count strobe in the same cycle still sets its bit.
- R9: A read at index 15 returns the mask in the low bits with zeros above. A read at any other index returns 0.
- R10: svc_en[c] is 1 exactly when channel c is unmasked and status bit 4+c is 1. When svc_en is nonzero, grant_ch is the lowest such channel.
- R11: While command bit 2 is 1, grant_vld is 0, and svc_en still reflects the eligible channels.
- R12: A terminal-count strobe for channel c sets status bit c. The strobe has precedence over a status read and a request write in the same cycle. Only a master reset beats it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| idx | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational, 0 when no read is decoded |
| dreq_set | input | NUM_CH | Per-channel hardware request hold |
| dreq_clr | input | NUM_CH | Per-channel hardware request release |
| tc_hit | input | NUM_CH | Per-channel terminal-count strobe |
| svc_en | output | NUM_CH | Channels that are unmasked and requested |
| grant_vld | output | 1 | A channel is granted |
| grant_ch | output | CH_W | Granted channel number |
| cmd_out | output | 8 | Current command byte |
| mode_out | output | 8*NUM_CH | Mode bytes, channel c at bits [8c+7:8c] |
| ptr_clr | output | 1 | Byte-pointer clear pulse |

## Verification
The hardest cases to produce are collisions inside a single cycle. Examples are a status read meeting a terminal-count strobe, a request write to a channel meeting its release line, and a hold and a release on the same channel. These cases can only be seen one edge later, and status cannot be inspected without clearing its low half. The stimulus therefore drives the colliding strobes together on one falling edge. It then follows with back-to-back status reads, and each read's expected value already accounts for the clear done by the read before it.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
   localparam int DW    = 8;
   localparam int IDX_W = 4;

   localparam logic [IDX_W-1:0] IX_CMD_STAT = 4'd8;
   localparam logic [IDX_W-1:0] IX_REQ      = 4'd9;
   localparam logic [IDX_W-1:0] IX_SMASK    = 4'd10;
   localparam logic [IDX_W-1:0] IX_MODE     = 4'd11;
   localparam logic [IDX_W-1:0] IX_PTRCLR   = 4'd12;
   localparam logic [IDX_W-1:0] IX_MRESET   = 4'd13;
   localparam logic [IDX_W-1:0] IX_MCLR     = 4'd14;
   localparam logic [IDX_W-1:0] IX_MASK     = 4'd15;

   localparam logic [DW-1:0] CMD_LEGAL = 8'h04;

   typedef struct packed {
      logic cmd_wr;
      logic req_wr;
      logic smask_wr;
      logic mode_wr;
      logic ptr_clr;
      logic mreset;
      logic mask_clr;
      logic mask_wr;
      logic stat_rd;
      logic mask_rd;
   } dmactl_strobe_t;

   function automatic logic cmd_ok(input logic [DW-1:0] d);
      return (d & ~CMD_LEGAL) == '0;
   endfunction
endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
   import dmactl_pkg::*;
(
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] idx,
   output dmactl_strobe_t   stb
);
   always_comb begin
      stb          = '0;
      stb.cmd_wr   = wr_en && (idx == IX_CMD_STAT);
      stb.req_wr   = wr_en && (idx == IX_REQ);
      stb.smask_wr = wr_en && (idx == IX_SMASK);
      stb.mode_wr  = wr_en && (idx == IX_MODE);
      stb.mreset   = wr_en && (idx == IX_MRESET);
      stb.ptr_clr  = wr_en && ((idx == IX_PTRCLR) || (idx == IX_MRESET));
      stb.mask_clr = wr_en && (idx == IX_MCLR);
      stb.mask_wr  = wr_en && (idx == IX_MASK);
      stb.stat_rd  = rd_en && (idx == IX_CMD_STAT);
      stb.mask_rd  = rd_en && (idx == IX_MASK);
   end
endmodule

// File: rtl/dmactl_chan.sv
module dmactl_chan
   import dmactl_pkg::*;
#(
   parameter int CH = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  dmactl_strobe_t stb,
   input  logic [DW-1:0]  wr_data,
   input  logic           hold,
   input  logic           release_i,
   input  logic           tc_i,
   output logic           mask_q,
   output logic           req_q,
   output logic           tc_q,
   output logic [DW-1:0]  mode_q
);
   logic sel;
   assign sel = (wr_data[1:0] == 2'(CH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (stb.mreset) begin
         mask_q <= 1'b1;
      end else if (stb.mask_clr) begin
         mask_q <= 1'b0;
      end else if (stb.mask_wr) begin
         mask_q <= wr_data[CH];
      end else if (stb.smask_wr && sel) begin
         mask_q <= wr_data[2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (stb.mreset) begin
         req_q <= 1'b0;
      end else if (stb.req_wr && sel) begin
         req_q <= wr_data[2];
      end else if (release_i) begin
         req_q <= 1'b0;
      end else if (hold) begin
         req_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= 1'b0;
      end else if (stb.mreset) begin
         tc_q <= 1'b0;
      end else if (tc_i) begin
         tc_q <= 1'b1;
      end else if ((stb.req_wr && sel) || stb.stat_rd) begin
         tc_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (stb.mode_wr && sel) begin
         mode_q <= wr_data;
      end
   end
endmodule

// File: rtl/dmactl_arb.sv
module dmactl_arb #(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] elig,
   input  logic              disable_i,
   output logic              vld,
   output logic [CH_W-1:0]   ch
);
   always_comb begin
      ch = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (elig[i]) ch = CH_W'(i);
      end
      vld = (|elig) && !disable_i;
   end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dmactl_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [IDX_W-1:0]     idx,
   input  logic [DW-1:0]        wr_data,
   output logic [DW-1:0]        rd_data,
   input  logic [NUM_CH-1:0]    dreq_set,
   input  logic [NUM_CH-1:0]    dreq_clr,
   input  logic [NUM_CH-1:0]    tc_hit,
   output logic [NUM_CH-1:0]    svc_en,
   output logic                 grant_vld,
   output logic [CH_W-1:0]      grant_ch,
   output logic [DW-1:0]        cmd_out,
   output logic [DW*NUM_CH-1:0] mode_out,
   output logic                 ptr_clr
);
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_num_ch
      $error("dma_ctl_regs: NUM_CH must lie in 1..4");
   end

   dmactl_strobe_t    stb;
   logic [NUM_CH-1:0] mask_vec;
   logic [NUM_CH-1:0] req_vec;
   logic [NUM_CH-1:0] tc_vec;
   logic [DW-1:0]     status_q;
   logic [DW-1:0]     mask_rd;
   logic [DW-1:0]     cmd_q;

   dmactl_decode u_dec (
      .wr_en (wr_en),
      .rd_en (rd_en),
      .idx   (idx),
      .stb   (stb)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmactl_chan #(.CH(c)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .stb       (stb),
         .wr_data   (wr_data),
         .hold      (dreq_set[c]),
         .release_i (dreq_clr[c]),
         .tc_i      (tc_hit[c]),
         .mask_q    (mask_vec[c]),
         .req_q     (req_vec[c]),
         .tc_q      (tc_vec[c]),
         .mode_q    (mode_out[DW*c +: DW])
      );
   end

   always_comb begin
      status_q = '0;
      mask_rd  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         status_q[c]     = tc_vec[c];
         status_q[4 + c] = req_vec[c];
         mask_rd[c]      = mask_vec[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (stb.mreset) begin
         cmd_q <= '0;
      end else if (stb.cmd_wr && cmd_ok(wr_data)) begin
         cmd_q <= wr_data;
      end
   end

   assign cmd_out = cmd_q;
   assign ptr_clr = stb.ptr_clr;
   assign svc_en  = ~mask_vec & req_vec;

   dmactl_arb #(.NUM_CH(NUM_CH)) u_arb (
      .elig      (svc_en),
      .disable_i (cmd_q[2]),
      .vld       (grant_vld),
      .ch        (grant_ch)
   );

   always_comb begin
      if (stb.stat_rd)      rd_data = status_q;
      else if (stb.mask_rd) rd_data = mask_rd;
      else                  rd_data = '0;
   end
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
   import dmactl_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [IDX_W-1:0]  idx,
   input logic [DW-1:0]     wr_data,
   input logic [NUM_CH-1:0] dreq_set,
   input logic [NUM_CH-1:0] dreq_clr,
   input logic [NUM_CH-1:0] tc_hit,
   input logic [NUM_CH-1:0] svc_en,
   input logic              grant_vld,
   input logic [CH_W-1:0]   grant_ch,
   input logic [DW-1:0]     cmd_out,
   input logic [DW-1:0]     status_q,
   input logic [NUM_CH-1:0] mask_vec
);
   logic mrst_w, stat_r;
   assign mrst_w = wr_en && (idx == IX_MRESET);
   assign stat_r = rd_en && (idx == IX_CMD_STAT);

   a_r1_cmd_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IX_CMD_STAT && (wr_data & 8'hFB) != 8'h00) |=> $stable(cmd_out));

   a_r7_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
      mrst_w |=> (cmd_out == 8'h00 && status_q == 8'h00 && (&mask_vec)));

   a_r11_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_out[2] |-> !grant_vld);

   a_r10_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> svc_en[grant_ch]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      logic rq_c, sm_c;
      assign rq_c = wr_en && idx == IX_REQ && wr_data[1:0] == 2'(c);
      assign sm_c = wr_en && idx == IX_SMASK && wr_data[1:0] == 2'(c);

      a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_vld && svc_en[c]) |-> (int'(grant_ch) <= c));

      a_r3_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
         (sm_c && !mrst_w) |=> (mask_vec[c] == $past(wr_data[2])));

      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (dreq_set[c] && !dreq_clr[c] && !rq_c && !mrst_w) |=> status_q[4 + c]);

      a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
         (dreq_clr[c] && !rq_c) |=> !status_q[4 + c]);

      a_r12_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (tc_hit[c] && !mrst_w) |=> status_q[c]);

      a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_r && !tc_hit[c]) |=> !status_q[c]);
   end
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .idx       (idx),
   .wr_data   (wr_data),
   .dreq_set  (dreq_set),
   .dreq_clr  (dreq_clr),
   .tc_hit    (tc_hit),
   .svc_en    (svc_en),
   .grant_vld (grant_vld),
   .grant_ch  (grant_ch),
   .cmd_out   (cmd_out),
   .status_q  (status_q),
   .mask_vec  (mask_vec)
);

// File: tb/tb_dma_ctl_regs.sv
module tb_dma_ctl_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]     idx = '0;
   logic [7:0]     wr_data = '0;
   logic [7:0]     rd_data;
   logic [NCH-1:0] dreq_set = '0, dreq_clr = '0, tc_hit = '0;
   logic [NCH-1:0] svc_en;
   logic           grant_vld;
   logic [1:0]     grant_ch;
   logic [7:0]     cmd_out;
   logic [31:0]    mode_out;
   logic           ptr_clr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_ctl_regs #(.NUM_CH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
      .wr_data(wr_data), .rd_data(rd_data), .dreq_set(dreq_set),
      .dreq_clr(dreq_clr), .tc_hit(tc_hit), .svc_en(svc_en),
      .grant_vld(grant_vld), .grant_ch(grant_ch), .cmd_out(cmd_out),
      .mode_out(mode_out), .ptr_clr(ptr_clr)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] i, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] i, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; idx = i;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic hw(input logic [NCH-1:0] s, input logic [NCH-1:0] c, input logic [NCH-1:0] t);
      @(negedge clk);
      dreq_set = s; dreq_clr = c; tc_hit = t;
      @(negedge clk);
      dreq_set = '0; dreq_clr = '0; tc_hit = '0;
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      check("R7 reset cmd", cmd_out, 0);
      check("R2 reset modes", mode_out, 0);
      check("R10 reset svc_en", svc_en, 0);
      check("R11 reset grant", grant_vld, 0);
      rd(4'd15, v); check("R7 reset mask", v, 8'h0F);
      rd(4'd8, v);  check("R7 reset status", v, 8'h00);
   endtask

   task automatic t_command();
      wr(4'd8, 8'h04); check("R1 cmd accept 04", cmd_out, 8'h04);
      wr(4'd8, 8'h01); check("R1 cmd reject 01", cmd_out, 8'h04);
      wr(4'd8, 8'h84); check("R1 cmd reject 84", cmd_out, 8'h04);
      wr(4'd8, 8'h00); check("R1 cmd accept 00", cmd_out, 8'h00);
   endtask

   task automatic t_mode();
      wr(4'd11, 8'h56);
      check("R2 mode ch2", mode_out, 32'h0056_0000);
      wr(4'd11, 8'hA9);
      check("R2 mode ch1", mode_out, 32'h0056_A900);
      wr(4'd11, 8'hFF);
      check("R2 mode ch3", mode_out, 32'hFF56_A900);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(4'd14, 8'h00); rd(4'd15, v); check("R4 clear all", v, 8'h00);
      wr(4'd10, 8'h05); rd(4'd15, v); check("R3 mask ch1", v, 8'h02);
      wr(4'd15, 8'hFA); rd(4'd15, v); check("R4 write all", v, 8'h0A);
      wr(4'd10, 8'h01); rd(4'd15, v); check("R3 unmask ch1", v, 8'h08);
      rd(4'd9, v); check("R9 other index", v, 8'h00);
      rd(4'd3, v); check("R9 low index", v, 8'h00);
   endtask

   task automatic t_request_grant();
      logic [7:0] v;
      wr(4'd13, 8'h00); wr(4'd14, 8'h00);
      wr(4'd9, 8'h06);
      check("R5 sw req svc", svc_en, 4'b0100);
      check("R10 grant ch2", {grant_vld, grant_ch}, 3'b110);
      hw(4'b0010, 4'b0000, 4'b0000);
      check("R10 lowest wins", {grant_vld, grant_ch}, 3'b101);
      wr(4'd10, 8'h05);
      check("R10 masked skip", {svc_en, grant_vld, grant_ch}, 7'b0100_110);
      hw(4'b0001, 4'b0001, 4'b0000);
      check("R6 release beats hold", svc_en, 4'b0100);
      hw(4'b0000, 4'b0100, 4'b0000);
      check("R6 release", {svc_en, grant_vld}, 5'b0000_0);
      @(negedge clk);
      wr_en = 1'b1; idx = 4'd9; wr_data = 8'h05; dreq_clr = 4'b0010;
      @(negedge clk);
      wr_en = 1'b0; dreq_clr = '0;
      rd(4'd8, v); check("R6 sw write beats release", v, 8'h20);
      wr(4'd9, 8'h01);
      rd(4'd8, v); check("R5 sw clear req", v, 8'h00);
   endtask

   task automatic t_disable();
      wr(4'd13, 8'h00); wr(4'd14, 8'h00);
      wr(4'd8, 8'h04);
      hw(4'b1000, 4'b0000, 4'b0000);
      check("R11 disabled svc", svc_en, 4'b1000);
      check("R11 disabled grant", grant_vld, 1'b0);
      wr(4'd8, 8'h00);
      check("R11 enabled grant", {grant_vld, grant_ch}, 3'b111);
   endtask

   task automatic t_tc();
      logic [7:0] v;
      wr(4'd13, 8'h00);
      hw(4'b0000, 4'b0000, 4'b1000);
      hw(4'b1000, 4'b0000, 4'b0000);
      rd(4'd8, v); check("R12 tc set", v, 8'h88);
      rd(4'd8, v); check("R8 read clears low", v, 8'h80);
      hw(4'b0000, 4'b0000, 4'b1000);
      wr(4'd9, 8'h03);
      rd(4'd8, v); check("R5 req write clears tc", v, 8'h00);
      hw(4'b0000, 4'b0000, 4'b0001);
      @(negedge clk);
      rd_en = 1'b1; idx = 4'd8; tc_hit = 4'b0010;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0; tc_hit = '0;
      check("R8 read value", v, 8'h01);
      rd(4'd8, v); check("R8 tc during read kept", v, 8'h02);
      rd(4'd8, v); check("R8 cleared", v, 8'h00);
      hw(4'b0000, 4'b0000, 4'b0100);
      @(negedge clk);
      rd_en = 1'b1; idx = 4'd8; tc_hit = 4'b0100;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0; tc_hit = '0;
      check("R12 read same bit", v, 8'h04);
      rd(4'd8, v); check("R12 tc beats clear", v, 8'h04);
   endtask

   task automatic t_master_reset();
      logic [7:0] v;
      wr(4'd14, 8'h00); wr(4'd8, 8'h04);
      hw(4'b0010, 4'b0000, 4'b0100);
      @(negedge clk);
      wr_en = 1'b1; idx = 4'd13; wr_data = 8'h00;
      #1 check("R7 ptr_clr on 13", ptr_clr, 1'b1);
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 cmd cleared", cmd_out, 8'h00);
      check("R7 svc cleared", {svc_en, grant_vld}, 5'b0);
      rd(4'd15, v); check("R7 mask set", v, 8'h0F);
      rd(4'd8, v);  check("R7 status cleared", v, 8'h00);
      @(negedge clk);
      wr_en = 1'b1; idx = 4'd12;
      #1 check("R7 ptr_clr on 12", ptr_clr, 1'b1);
      idx = 4'd14;
      #1 check("R7 no ptr_clr on 14", ptr_clr, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_command();
      t_mode();
      t_mask();
      t_request_grant();
      t_disable();
      t_tc();
      t_master_reset();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule